// File: doc/BRIEF.md
# Pulse-Width Coded One-Wire Register Slave

This block is the device end of a bidirectional host link that runs over a single wire. The wire idles high through an external pull-up. Either side signals only by pulling it low. Every bit is a frame that opens with a falling edge. The length of the low period that follows carries the bit value, and the wire is high again before the frame closes. A host low that lasts longer than any legal bit is a break. A break drops whatever transfer was in progress, and the device then waits for a fresh command once the wire has gone high.

The host sends a command byte. Bit 7 selects the direction and bits 6:0 carry a register address. For a write, one more host byte follows and is handed to a plain register-file port as a single write strobe. For a read, the device issues a single read strobe and captures the data. After a quiet turnaround it sends the byte back on the same wire, using the same low-pulse framing. While the rest of the system sleeps, any edge on the wire raises a wake request. All timing thresholds are clock-count parameters, so the block can be matched to any clock rate up to the link's 5 kbit/s ceiling.

Top module: `pwl_slave`

## Requirements
- R1: Out of reset the device releases the wire (`line_pull_o` = 0), and `reg_wr_o`, `reg_rd_o` and `wake_o` are all 0.
- R2: A low level on the synchronised wire that lasts BREAK_CYC cycles is a break. It aborts any transfer in progress, and once the wire is high again the next eight host bits are taken as a new command.
- R3: A host bit is decoded from the synchronised wire level SAMPLE_CYC cycles after its falling edge: low decodes as 0, high decodes as 1.
- R4: Bytes travel least significant bit first in both directions. In the command byte, bit 7 = 1 means write, bit 7 = 0 means read, and bits 6:0 are the register address.
- R5: After a write command and eight data bits, `reg_wr_o` is high for exactly one cycle, with `reg_addr_o` equal to the command address and `reg_wdata_o` equal to the data byte.
- R6: After a read command, `reg_rd_o` is high for exactly one cycle with `reg_addr_o` equal to the command address. `reg_rdata_i` is captured during that cycle.
- R7: A read reply starts after the wire has been high for TURN_CYC cycles. It sends the captured byte LSB first. Each bit pulls the wire low for TX_ONE_LOW cycles for a 1, or TX_ZERO_LOW cycles for a 0, inside a TX_BIT_CYC cycle frame.
- R8: A break during a reply stops it. The device releases the wire within one cycle of detecting the break, and it does not pull again until a new read command arrives.
- R9: While `sleep_i` is high, each falling or rising edge of the synchronised wire raises `wake_o` for one cycle. While `sleep_i` is low, `wake_o` stays 0.
- R10: The device pulls the wire only while it is sending a read reply. During host commands and host data it never pulls.
- R11: A write that is cut off by a break before its eighth data bit produces no `reg_wr_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw level of the shared wire (asynchronous) |
| line_pull_o | output | 1 | 1 = drive the wire low through the open-drain stage, 0 = release |
| sleep_i | input | 1 | System is asleep; edges on the wire raise wake requests |
| wake_o | output | 1 | One-cycle wake request |
| reg_addr_o | output | 7 | Register address from the last command |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Register read data, captured while `reg_rd_o` is high |

## Verification
The bench builds the block with BREAK_CYC = 64, SAMPLE_CYC = 16, TURN_CYC = 40, TX_ONE_LOW = 6, TX_ZERO_LOW = 24 and TX_BIT_CYC = 40. With these values a whole command, reply or break lasts only a few hundred cycles, so many transactions fit in one run. The short reply pulses can be measured to the exact cycle, and host pulses can be placed just on either side of the sample point. The break length sits well above the longest legal low, which lets a break be laid over a device reply and over a half-sent byte.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    // Register address width; the command byte adds one direction bit on top.
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned DATA_W = ADDR_W + 1;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        LS_RESYNC = 3'd0,   // wait for the wire to go high after reset or a break
        LS_CMD    = 3'd1,   // collecting command bits
        LS_WDATA  = 3'd2,   // collecting write data bits
        LS_TURN   = 3'd3,   // quiet gap before the reply
        LS_REPLY  = 3'd4    // device drives the reply byte
    } link_state_e;

    typedef struct packed {
        logic  wr;
        addr_t addr;
    } cmd_t;

    // Counter width able to hold values 0..m.
    function automatic int cnt_w(input int m);
        return (m < 2) ? 1 : $clog2(m + 1);
    endfunction

    // Top bit picks the direction, the rest is the address.
    function automatic cmd_t decode_cmd(input byte_t b);
        cmd_t c;
        c.wr   = b[DATA_W-1];
        c.addr = b[ADDR_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/pwl_line_mon.sv
module pwl_line_mon #(
    parameter int unsigned BREAK_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o,
    output logic brk_o
);
    localparam int BW = pwl_pkg::cnt_w(BREAK_CYC);
    localparam logic [BW-1:0] BRK_LAST = BW'(BREAK_CYC - 1);
    localparam logic [BW-1:0] BRK_SAT  = BW'(BREAK_CYC);

    logic s1_q, s2_q, s3_q;
    logic [BW-1:0] low_q;

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= line_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Length of the current low period, saturating at the break threshold.
    always_ff @(posedge clk) begin
        if (rst || s2_q) begin
            low_q <= '0;
        end else if (low_q != BRK_SAT) begin
            low_q <= low_q + BW'(1);
        end
    end

    assign lvl_o  = s2_q;
    assign fall_o = s3_q & ~s2_q;
    assign rise_o = ~s3_q & s2_q;
    assign brk_o  = ~s2_q && (low_q == BRK_LAST);

    // R2: one low period reports its break only once
    a_r2_break_once: assert property (@(posedge clk) disable iff (rst)
        brk_o |=> !brk_o);

endmodule

// File: rtl/pwl_bit_rx.sv
module pwl_bit_rx #(
    parameter int unsigned SAMPLE_CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic clr_i,
    input  logic lvl_i,
    input  logic fall_i,
    output logic bit_vld_o,
    output logic bit_val_o
);
    localparam int SW = pwl_pkg::cnt_w(SAMPLE_CYC);
    localparam logic [SW-1:0] SMP_LAST = SW'(SAMPLE_CYC - 1);

    logic          armed_q;
    logic [SW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            bit_vld_o <= 1'b0;
            bit_val_o <= 1'b0;
        end else begin
            bit_vld_o <= 1'b0;
            if (clr_i || !en_i) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (fall_i) begin
                armed_q <= 1'b1;
                cnt_q   <= '0;
            end else if (armed_q) begin
                if (cnt_q == SMP_LAST) begin
                    armed_q   <= 1'b0;
                    bit_vld_o <= 1'b1;
                    bit_val_o <= lvl_i;   // R3: low = 0, high = 1
                end else begin
                    cnt_q <= cnt_q + SW'(1);
                end
            end
        end
    end

    // R3: at most one decoded bit per falling edge
    a_r3_one_bit_per_edge: assert property (@(posedge clk) disable iff (rst)
        bit_vld_o |=> !bit_vld_o);

endmodule

// File: rtl/pwl_bit_tx.sv
module pwl_bit_tx #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned TX_ONE_LOW  = 2000,
    parameter int unsigned TX_ZERO_LOW = 7000,
    parameter int unsigned TX_BIT_CYC  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pull_o,
    output logic              done_o
);
    localparam int CW = pwl_pkg::cnt_w(TX_BIT_CYC);
    localparam int IW = pwl_pkg::cnt_w(DATA_W - 1);
    localparam logic [CW-1:0] ONE_LAST  = CW'(TX_ONE_LOW - 1);
    localparam logic [CW-1:0] ZERO_LAST = CW'(TX_ZERO_LOW - 1);
    localparam logic [CW-1:0] BIT_LAST  = CW'(TX_BIT_CYC - 1);
    localparam logic [IW-1:0] IDX_LAST  = IW'(DATA_W - 1);

    logic              busy_q;
    logic [CW-1:0]     cnt_q;
    logic [IW-1:0]     idx_q;
    logic [DATA_W-1:0] sh_q;
    logic [CW-1:0]     low_last;

    // Low length of the bit now on the wire.
    assign low_last = sh_q[0] ? ONE_LAST : ZERO_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pull_o <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
        end else begin
            done_o <= 1'b0;
            if (abort_i) begin
                busy_q <= 1'b0;
                pull_o <= 1'b0;
            end else if (start_i) begin
                busy_q <= 1'b1;
                pull_o <= 1'b1;
                cnt_q  <= '0;
                idx_q  <= '0;
                sh_q   <= data_i;
            end else if (busy_q) begin
                if (cnt_q == BIT_LAST) begin
                    cnt_q <= '0;
                    if (idx_q == IDX_LAST) begin
                        busy_q <= 1'b0;
                        done_o <= 1'b1;
                        pull_o <= 1'b0;
                    end else begin
                        idx_q  <= idx_q + IW'(1);
                        sh_q   <= sh_q >> 1;    // R4: LSB leaves first
                        pull_o <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == low_last) begin
                        pull_o <= 1'b0;
                    end
                end
            end
        end
    end

    // R7: a low never outlasts the zero-bit length
    a_r7_low_bounded: assert property (@(posedge clk) disable iff (rst)
        pull_o |-> (cnt_q <= ZERO_LAST));

    // R7: each bit frame releases the wire before the next one starts
    a_r7_release_before_frame_end: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q == BIT_LAST) |-> !pull_o);

endmodule

// File: rtl/pwl_slave.sv
module pwl_slave
    import pwl_pkg::*;
#(
    parameter int unsigned BREAK_CYC   = 10000,
    parameter int unsigned SAMPLE_CYC  = 5000,
    parameter int unsigned TURN_CYC    = 5000,
    parameter int unsigned TX_ONE_LOW  = 2000,
    parameter int unsigned TX_ZERO_LOW = 7000,
    parameter int unsigned TX_BIT_CYC  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_i,
    output logic              line_pull_o,
    input  logic              sleep_i,
    output logic              wake_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_rd_o,
    input  logic [DATA_W-1:0] reg_rdata_i
);
    localparam int TW = cnt_w(TURN_CYC);
    localparam int BC = cnt_w(DATA_W - 1);
    localparam logic [TW-1:0] TURN_LAST = TW'(TURN_CYC - 1);
    localparam logic [BC-1:0] BIT_LAST  = BC'(DATA_W - 1);

    logic lvl, fall, rise, brk;
    logic rx_en, rx_vld, rx_bit;
    logic tx_start, tx_done;

    link_state_e   state_q;
    byte_t         sh_q;
    byte_t         byte_nx;
    logic [BC-1:0] bit_q;
    cmd_t          cmd_q;
    cmd_t          cmd_nx;
    logic [TW-1:0] turn_q;
    byte_t         rdata_q;
    byte_t         wdata_q;
    logic          wr_q, rd_q, wake_q;

    pwl_line_mon #(.BREAK_CYC(BREAK_CYC)) u_mon (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_i),
        .lvl_o  (lvl),
        .fall_o (fall),
        .rise_o (rise),
        .brk_o  (brk)
    );

    assign rx_en = (state_q == LS_CMD) || (state_q == LS_WDATA);

    pwl_bit_rx #(.SAMPLE_CYC(SAMPLE_CYC)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en_i      (rx_en),
        .clr_i     (brk),
        .lvl_i     (lvl),
        .fall_i    (fall),
        .bit_vld_o (rx_vld),
        .bit_val_o (rx_bit)
    );

    pwl_bit_tx #(
        .DATA_W      (DATA_W),
        .TX_ONE_LOW  (TX_ONE_LOW),
        .TX_ZERO_LOW (TX_ZERO_LOW),
        .TX_BIT_CYC  (TX_BIT_CYC)
    ) u_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (tx_start),
        .abort_i (brk),
        .data_i  (rdata_q),
        .pull_o  (line_pull_o),
        .done_o  (tx_done)
    );

    // Incoming bits enter at the top, so the first bit ends up as bit 0.
    assign byte_nx = {rx_bit, sh_q[DATA_W-1:1]};
    assign cmd_nx  = decode_cmd(byte_nx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LS_RESYNC;
            sh_q     <= '0;
            bit_q    <= '0;
            cmd_q    <= '0;
            turn_q   <= '0;
            rdata_q  <= '0;
            wdata_q  <= '0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            tx_start <= 1'b0;
        end else begin
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            tx_start <= 1'b0;
            if (rd_q) begin
                rdata_q <= reg_rdata_i;          // R6: capture during the strobe
            end
            if (brk) begin
                state_q <= LS_RESYNC;            // R2, R8, R11: break wins
                bit_q   <= '0;
            end else begin
                unique case (state_q)
                    LS_RESYNC: begin
                        bit_q <= '0;
                        if (lvl) state_q <= LS_CMD;
                    end
                    LS_CMD: begin
                        if (rx_vld) begin
                            sh_q  <= byte_nx;
                            bit_q <= bit_q + BC'(1);
                            if (bit_q == BIT_LAST) begin
                                cmd_q <= cmd_nx;
                                if (cmd_nx.wr) begin
                                    state_q <= LS_WDATA;
                                end else begin
                                    state_q <= LS_TURN;
                                    rd_q    <= 1'b1;
                                    turn_q  <= '0;
                                end
                            end
                        end
                    end
                    LS_WDATA: begin
                        if (rx_vld) begin
                            sh_q  <= byte_nx;
                            bit_q <= bit_q + BC'(1);
                            if (bit_q == BIT_LAST) begin
                                wdata_q <= byte_nx;
                                wr_q    <= 1'b1;
                                state_q <= LS_CMD;
                            end
                        end
                    end
                    LS_TURN: begin
                        if (!lvl) begin
                            turn_q <= '0;
                        end else if (turn_q == TURN_LAST) begin
                            tx_start <= 1'b1;
                            state_q  <= LS_REPLY;
                        end else begin
                            turn_q <= turn_q + TW'(1);
                        end
                    end
                    LS_REPLY: begin
                        bit_q <= '0;
                        if (tx_done) state_q <= LS_CMD;
                    end
                    default: state_q <= LS_RESYNC;
                endcase
            end
        end
    end

    // Wake request on either edge while asleep.
    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= sleep_i & (fall | rise);
    end

    assign reg_addr_o  = cmd_q.addr;
    assign reg_wdata_o = wdata_q;
    assign reg_wr_o    = wr_q;
    assign reg_rd_o    = rd_q;
    assign wake_o      = wake_q;

    // R5: write strobe lasts one cycle
    a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    // R6: read strobe lasts one cycle
    a_r6_rd_single: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |=> !reg_rd_o);

    // R4: a command is either a read or a write
    a_r4_wr_rd_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_o && reg_rd_o));

    // R8: a break releases the wire on the next cycle
    a_r8_break_releases: assert property (@(posedge clk) disable iff (rst)
        brk |=> !line_pull_o);

    // R11: no write strobe right after a break
    a_r11_no_wr_after_break: assert property (@(posedge clk) disable iff (rst)
        brk |=> !reg_wr_o);

    // R10: the wire is pulled only while replying
    a_r10_pull_only_reply: assert property (@(posedge clk) disable iff (rst)
        line_pull_o |-> (state_q == LS_REPLY));

    // R9: no wake request unless asleep
    a_r9_wake_needs_sleep: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> $past(sleep_i));

endmodule

// File: tb/pwl_slave_bench.sv
module pwl_slave_bench;
    localparam int BRK  = 64;
    localparam int SMP  = 16;
    localparam int TURN = 40;
    localparam int ONE  = 6;
    localparam int ZERO = 24;
    localparam int BITC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_pull = 1'b0;
    logic       line;
    logic       line_pull_o;
    logic       sleep_i = 1'b0;
    logic       wake_o;
    logic [6:0] reg_addr_o;
    logic       reg_wr_o;
    logic [7:0] reg_wdata_o;
    logic       reg_rd_o;
    logic [7:0] reg_rdata_i;

    logic [7:0] mem [0:127];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0, rd_cnt = 0, wake_cnt = 0, pull_cnt = 0;
    logic [6:0] last_wa, last_ra;
    logic [7:0] last_wd;
    logic       pull_prev = 1'b0;

    always #10 clk = ~clk;

    assign line        = ~(host_pull | line_pull_o);
    assign reg_rdata_i = mem[reg_addr_o];

    pwl_slave #(
        .BREAK_CYC(BRK), .SAMPLE_CYC(SMP), .TURN_CYC(TURN),
        .TX_ONE_LOW(ONE), .TX_ZERO_LOW(ZERO), .TX_BIT_CYC(BITC)
    ) u_pwl_slave (
        .clk(clk), .rst(rst), .line_i(line), .line_pull_o(line_pull_o),
        .sleep_i(sleep_i), .wake_o(wake_o), .reg_addr_o(reg_addr_o),
        .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o), .reg_rd_o(reg_rd_o),
        .reg_rdata_i(reg_rdata_i)
    );

    // Port observers.
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr_o) begin
                wr_cnt  <= wr_cnt + 1;
                last_wa <= reg_addr_o;
                last_wd <= reg_wdata_o;
                mem[reg_addr_o] <= reg_wdata_o;
            end
            if (reg_rd_o) begin
                rd_cnt  <= rd_cnt + 1;
                last_ra <= reg_addr_o;
            end
            if (wake_o) wake_cnt <= wake_cnt + 1;
            if (line_pull_o && !pull_prev) pull_cnt <= pull_cnt + 1;
            pull_prev <= line_pull_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host bit frame with chosen low lengths.
    task automatic host_bit_w(input logic b, input int w1, input int w0);
        int w;
        w = b ? w1 : w0;
        host_pull = 1'b1;
        idle(w);
        host_pull = 1'b0;
        idle(BITC - w);
    endtask

    task automatic host_byte_w(input logic [7:0] x, input int w1, input int w0);
        for (int i = 0; i < 8; i++) host_bit_w(x[i], w1, w0);
    endtask

    task automatic host_byte(input logic [7:0] x);
        host_byte_w(x, 6, 28);
    endtask

    task automatic host_break();
        host_pull = 1'b1;
        idle(BRK + 16);
        host_pull = 1'b0;
        idle(10);
    endtask

    // Receive a reply, checking each low length against the expected byte.
    task automatic get_reply(input logic [7:0] exp, input string req);
        logic [7:0] got;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            int t = 0;
            int w = 0;
            while (line && t < 400) begin @(negedge clk); t++; end
            while (!line && w < 400) begin @(negedge clk); w++; end
            got[i] = (w < (ONE + ZERO) / 2);
            chk({req, " R7 pulse width"}, w, exp[i] ? ONE : ZERO);
        end
        chk({req, " R4 reply byte"}, got, exp);
        idle(BITC);
    endtask

    task automatic t_reset();
        chk("R1 pull after reset", line_pull_o, 0);
        chk("R1 wr after reset", reg_wr_o, 0);
        chk("R1 rd after reset", reg_rd_o, 0);
        chk("R1 wake after reset", wake_o, 0);
    endtask

    task automatic t_write(input logic [6:0] a, input logic [7:0] d);
        int w0 = wr_cnt;
        int p0 = pull_cnt;
        host_byte({1'b1, a});
        host_byte(d);
        idle(10);
        chk("R5 one write strobe", wr_cnt - w0, 1);
        chk("R4 write address", last_wa, a);
        chk("R5 write data", last_wd, d);
        chk("R10 no pull in write", pull_cnt - p0, 0);
    endtask

    task automatic t_read(input logic [6:0] a);
        int r0 = rd_cnt;
        host_byte({1'b0, a});
        idle(2);
        chk("R6 one read strobe", rd_cnt - r0, 1);
        chk("R6 read address", last_ra, a);
        get_reply(mem[a], "R6");
    endtask

    task automatic t_sample_point();
        int w0 = wr_cnt;
        // lows of 12 stay ahead of the sample point, lows of 20 reach past it
        host_byte_w(8'h80 | 8'h2A, 12, 20);
        host_byte_w(8'hC5, 12, 20);
        idle(10);
        chk("R3 boundary write count", wr_cnt - w0, 1);
        chk("R3 boundary address", last_wa, 7'h2A);
        chk("R3 boundary data", last_wd, 8'hC5);
    endtask

    task automatic t_break_cmd();
        int w0 = wr_cnt;
        for (int i = 0; i < 4; i++) host_bit_w(i[0], 6, 28);
        host_break();
        host_byte(8'h83);
        host_byte(8'h3C);
        idle(10);
        chk("R2 write after break count", wr_cnt - w0, 1);
        chk("R2 write after break addr", last_wa, 7'h03);
        chk("R2 write after break data", last_wd, 8'h3C);
    endtask

    task automatic t_break_wdata();
        int w0 = wr_cnt;
        host_byte(8'h85);
        for (int i = 0; i < 5; i++) host_bit_w(1'b1, 6, 28);
        host_break();
        idle(20);
        chk("R11 aborted write count", wr_cnt - w0, 0);
        chk("R11 register kept", mem[5], 8'h5F);
    endtask

    task automatic t_break_reply();
        int t = 0;
        int p0;
        host_byte(8'h11);
        while (line && t < 400) begin @(negedge clk); t++; end
        host_pull = 1'b1;
        idle(BRK + 16);
        host_pull = 1'b0;
        idle(5);
        p0 = pull_cnt;
        idle(600);
        chk("R8 no pulls after break", pull_cnt - p0, 0);
        chk("R8 wire released", line_pull_o, 0);
        t_read(7'h11);
    endtask

    task automatic t_wake();
        int k0 = wake_cnt;
        sleep_i = 1'b1;
        host_pull = 1'b1;
        idle(5);
        host_pull = 1'b0;
        idle(10);
        chk("R9 two edges while asleep", wake_cnt - k0, 2);
        sleep_i = 1'b0;
        k0 = wake_cnt;
        host_pull = 1'b1;
        idle(5);
        host_pull = 1'b0;
        idle(10);
        chk("R9 no wake while awake", wake_cnt - k0, 0);
        host_break();
        chk("R9 no wake from break", wake_cnt - k0, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i) ^ 8'h5A;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle(4);
        t_reset();
        t_write(7'h15, 8'hA6);
        t_write(7'h7F, 8'h01);
        t_write(7'h00, 8'hFF);
        t_read(7'h15);
        t_read(7'h2C);
        t_read(7'h00);
        t_sample_point();
        t_break_cmd();
        t_break_wdata();
        t_break_reply();
        t_wake();
        t_read(7'h7F);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule